// File: doc/BRIEF.md
# Virtualized Trap Entry and Return Controller

This block holds the hart's current privilege level and its virtualization flag, and it is the single place where both change. When a trap request arrives, carrying a cause code, an interrupt flag and an environment-call flag, the block picks the handling mode. It walks a delegation chain built from a machine-level mask and a hypervisor-level mask. The hypervisor mask takes part only while a guest is running. The block then records where the hart came from, saves the interrupt enable of the mode it enters, and raises a one-cycle swap strobe. That strobe tells the CSR file to exchange its foreground and background supervisor register sets.

The same block executes the three return instructions: machine return, supervisor return and hypervisor return. Each one restores the privilege level, and where the rules allow it, the virtualization flag. Each one re-enables interrupts from the saved copy. A return that changes the virtualization flag also pulses the swap strobe.

All results are registered. They appear one clock edge after the request is sampled.

Top module: `vtrap_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the privilege to machine (3), the virtualization flag to 0, every saved-mode and enable bit to 0, the handler code to 0, the reported cause to 0, and the swap and return-fault pulses to 0.
- R2: A trap taken with the virtualization flag at 0 goes to the host supervisor (handler code 1) when the privilege is user or supervisor and the machine mask bit indexed by the cause is set. The exception mask is used for exceptions and the interrupt mask for interrupts. Otherwise the trap goes to machine (handler code 3). A trap taken in machine mode always stays in machine. The hypervisor masks have no effect.
- R3: With the virtualization flag at 1, a trap goes to machine if the machine bit is clear. It goes to the guest supervisor (handler code 2) if both the machine bit and the hypervisor bit are set. It goes to the host supervisor in every other case.
- R4: An exception flagged as a host-level translation fault never reaches the guest, whatever the hypervisor exception mask holds.
- R5: Entry to machine saves the old privilege and the old virtualization flag into the machine saved fields. It moves the machine enable into its saved copy and clears the machine enable. It then sets the privilege to 3 and the virtualization flag to 0.
- R6: Entry to the host supervisor saves the old virtualization flag and bit 0 of the old privilege into the supervisor saved fields. It moves the supervisor enable into its saved copy and clears the supervisor enable. It then sets the privilege to 1 and the virtualization flag to 0.
- R7: Entry to the guest supervisor updates only the supervisor saved privilege and the supervisor enable pair. The saved virtualization bit is left unchanged, the virtualization flag stays 1 and no swap is signalled.
- R8: The swap strobe is high for exactly the one cycle that follows an edge at which the virtualization flag changed, and it is low otherwise.
- R9: A machine return (return kind 0) sets the privilege from the machine saved privilege. It sets the virtualization flag from the machine saved flag, or to 0 when the saved privilege is 3. It then clears the saved privilege, copies the saved enable into the enable, and sets the saved enable to 1.
- R10: A supervisor return (return kind 1) sets the privilege to 1 or 0 according to the supervisor saved privilege. When the virtualization flag is 0, it also loads the flag from the supervisor saved flag. When the flag is 1, the flag stays 1. It then clears the saved privilege, copies the saved enable into the enable, and sets the saved enable to 1. Return kind 3 is reserved and changes nothing.
- R11: A hypervisor return (return kind 2) first sets the supervisor saved flag to 1 and then acts as a supervisor return. It is legal in machine mode, and in host supervisor mode when the trap-return control input is 0. Anywhere else it changes no state and pulses the return-fault output for one cycle.
- R12: An environment-call trap uses cause 8 from user mode, 9 from the host supervisor, 10 from the guest supervisor and 11 from machine. It is treated as an exception, and its cause is both used for delegation and reported.
- R13: When a trap request and a return request arrive in the same cycle, only the trap takes effect.
- R14: A return that changes the virtualization flag pulses the swap strobe in the cycle its other updates appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt (0 = exception) |
| trap_is_ecall | input | 1 | Trap is an environment call; the cause is generated internally |
| trap_code | input | CAUSE_W | Cause code for non-ecall traps |
| trap_host_fault | input | 1 | Exception came from host-level address translation |
| mdel_exc | input | 2**CAUSE_W | Machine exception delegation mask |
| mdel_irq | input | 2**CAUSE_W | Machine interrupt delegation mask |
| hdel_exc | input | 2**CAUSE_W | Hypervisor exception delegation mask |
| hdel_irq | input | 2**CAUSE_W | Hypervisor interrupt delegation mask |
| ret_req | input | 1 | Execute a return this cycle |
| ret_kind | input | 2 | 0 machine, 1 supervisor, 2 hypervisor, 3 reserved |
| sret_trap_ctl | input | 1 | Trap-return control; 1 makes a hypervisor return illegal in host supervisor mode |
| cur_priv | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | output | 1 | Virtualization flag |
| m_prev_priv | output | 2 | Machine saved privilege |
| m_prev_virt | output | 1 | Machine saved virtualization flag |
| s_prev_priv | output | 1 | Supervisor saved privilege |
| s_prev_virt | output | 1 | Supervisor saved virtualization flag |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine saved interrupt enable |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor saved interrupt enable |
| handler | output | 2 | Mode that took the last trap (1 host, 2 guest, 3 machine) |
| cause_q | output | CAUSE_W | Cause of the last trap |
| swap_strobe | output | 1 | One-cycle request to exchange supervisor register sets |
| ret_fault | output | 1 | One-cycle pulse for an illegal hypervisor return |

## Verification
Every output comes from a register that is loaded at the clock edge where the request is sampled, so each result is due exactly one edge after the request. The two pulses, swap and return fault, last only for the cycle after that edge. The bench drives a request just after a falling edge and holds it across one rising edge. It compares the whole output set a short delay after that rising edge, and then replaces the request before the next rising edge. The swap strobe and the fault pulse are therefore checked in their single valid cycle. An idle cycle follows in the sequences, so a stale pulse would be seen as a miscompare.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [1:0] TGT_NONE = 2'd0;
  localparam logic [1:0] TGT_HS   = 2'd1;
  localparam logic [1:0] TGT_VS   = 2'd2;
  localparam logic [1:0] TGT_M    = 2'd3;

  localparam logic [1:0] RK_MACH = 2'd0;
  localparam logic [1:0] RK_SUP  = 2'd1;
  localparam logic [1:0] RK_HYP  = 2'd2;

  localparam int unsigned ECALL_BASE = 8;

  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic [1:0] m_pp;
    logic       m_pv;
    logic       s_pp;
    logic       s_pv;
    logic       m_ie;
    logic       m_pie;
    logic       s_ie;
    logic       s_pie;
  } hart_st_t;

endpackage

// File: rtl/vtrap_route.sv
module vtrap_route
  import vtrap_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  hart_st_t                cur,
  input  logic                    is_irq,
  input  logic                    is_ecall,
  input  logic [CAUSE_W-1:0]      code,
  input  logic                    host_fault,
  input  logic [(1<<CAUSE_W)-1:0] m_exc,
  input  logic [(1<<CAUSE_W)-1:0] m_irq,
  input  logic [(1<<CAUSE_W)-1:0] h_exc,
  input  logic [(1<<CAUSE_W)-1:0] h_irq,
  output logic [1:0]              tgt,
  output logic [CAUSE_W-1:0]      eff_cause,
  output hart_st_t                nxt,
  output logic                    swap
);

  localparam logic [CAUSE_W-1:0] EC_BASE = CAUSE_W'(ECALL_BASE);

  logic [1:0] ec_off;
  logic       eff_irq;
  logic       m_bit;
  logic       h_bit;
  logic       guest_ok;

  always_comb begin
    unique case (cur.priv)
      PRV_U:   ec_off = 2'd0;
      PRV_S:   ec_off = cur.virt ? 2'd2 : 2'd1;
      default: ec_off = 2'd3;
    endcase
    eff_cause = is_ecall ? (EC_BASE + CAUSE_W'(ec_off)) : code;
    eff_irq   = is_irq & ~is_ecall;
  end

  always_comb begin
    m_bit    = eff_irq ? m_irq[eff_cause] : m_exc[eff_cause];
    h_bit    = eff_irq ? h_irq[eff_cause] : h_exc[eff_cause];
    guest_ok = h_bit & ~(host_fault & ~eff_irq);
    if (cur.priv == PRV_M || !m_bit) tgt = TGT_M;
    else if (cur.virt && guest_ok)   tgt = TGT_VS;
    else                             tgt = TGT_HS;
  end

  always_comb begin
    nxt  = cur;
    swap = 1'b0;
    unique case (tgt)
      TGT_M: begin
        nxt.m_pv  = cur.virt;
        nxt.m_pp  = cur.priv;
        nxt.m_pie = cur.m_ie;
        nxt.m_ie  = 1'b0;
        nxt.priv  = PRV_M;
        nxt.virt  = 1'b0;
        swap      = cur.virt;
      end
      TGT_VS: begin
        nxt.s_pp  = cur.priv[0];
        nxt.s_pie = cur.s_ie;
        nxt.s_ie  = 1'b0;
        nxt.priv  = PRV_S;
      end
      default: begin
        nxt.s_pv  = cur.virt;
        nxt.s_pp  = cur.priv[0];
        nxt.s_pie = cur.s_ie;
        nxt.s_ie  = 1'b0;
        nxt.priv  = PRV_S;
        nxt.virt  = 1'b0;
        swap      = cur.virt;
      end
    endcase
  end

endmodule

// File: rtl/vtrap_ret.sv
module vtrap_ret
  import vtrap_pkg::*;
(
  input  hart_st_t   cur,
  input  logic [1:0] kind,
  input  logic       trap_ctl,
  output hart_st_t   nxt,
  output logic       swap,
  output logic       fault
);

  logic hyp_legal;
  logic pv_eff;

  always_comb begin
    hyp_legal = (cur.priv == PRV_M) ||
                (cur.priv == PRV_S && !cur.virt && !trap_ctl);
    pv_eff    = (kind == RK_HYP) ? 1'b1 : cur.s_pv;
    nxt       = cur;
    fault     = 1'b0;
    unique case (kind)
      RK_MACH: begin
        nxt.priv  = cur.m_pp;
        nxt.virt  = (cur.m_pp == PRV_M) ? 1'b0 : cur.m_pv;
        nxt.m_pp  = PRV_U;
        nxt.m_ie  = cur.m_pie;
        nxt.m_pie = 1'b1;
      end
      RK_SUP, RK_HYP: begin
        if (kind == RK_HYP && !hyp_legal) begin
          fault = 1'b1;
        end else begin
          nxt.s_pv  = pv_eff;
          nxt.priv  = cur.s_pp ? PRV_S : PRV_U;
          nxt.virt  = cur.virt ? 1'b1 : pv_eff;
          nxt.s_pp  = 1'b0;
          nxt.s_ie  = cur.s_pie;
          nxt.s_pie = 1'b1;
        end
      end
      default: ;
    endcase
    swap = (nxt.virt != cur.virt);
  end

endmodule

// File: rtl/vtrap_ctrl.sv
module vtrap_ctrl
  import vtrap_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trap_req,
  input  logic                    trap_is_irq,
  input  logic                    trap_is_ecall,
  input  logic [CAUSE_W-1:0]      trap_code,
  input  logic                    trap_host_fault,
  input  logic [(1<<CAUSE_W)-1:0] mdel_exc,
  input  logic [(1<<CAUSE_W)-1:0] mdel_irq,
  input  logic [(1<<CAUSE_W)-1:0] hdel_exc,
  input  logic [(1<<CAUSE_W)-1:0] hdel_irq,
  input  logic                    ret_req,
  input  logic [1:0]              ret_kind,
  input  logic                    sret_trap_ctl,
  output logic [1:0]              cur_priv,
  output logic                    cur_virt,
  output logic [1:0]              m_prev_priv,
  output logic                    m_prev_virt,
  output logic                    s_prev_priv,
  output logic                    s_prev_virt,
  output logic                    m_ie,
  output logic                    m_pie,
  output logic                    s_ie,
  output logic                    s_pie,
  output logic [1:0]              handler,
  output logic [CAUSE_W-1:0]      cause_q,
  output logic                    swap_strobe,
  output logic                    ret_fault
);

  hart_st_t           st_q;
  hart_st_t           ent_nxt;
  hart_st_t           ret_nxt;
  logic [1:0]         tgt;
  logic [CAUSE_W-1:0] eff_cause;
  logic               ent_swap;
  logic               ret_swap;
  logic               ret_bad;
  logic [1:0]         hdl_q;
  logic [CAUSE_W-1:0] cause_r;
  logic               swap_q;
  logic               fault_q;

  vtrap_route #(.CAUSE_W(CAUSE_W)) route_i (
    .cur        (st_q),
    .is_irq     (trap_is_irq),
    .is_ecall   (trap_is_ecall),
    .code       (trap_code),
    .host_fault (trap_host_fault),
    .m_exc      (mdel_exc),
    .m_irq      (mdel_irq),
    .h_exc      (hdel_exc),
    .h_irq      (hdel_irq),
    .tgt        (tgt),
    .eff_cause  (eff_cause),
    .nxt        (ent_nxt),
    .swap       (ent_swap)
  );

  vtrap_ret ret_i (
    .cur      (st_q),
    .kind     (ret_kind),
    .trap_ctl (sret_trap_ctl),
    .nxt      (ret_nxt),
    .swap     (ret_swap),
    .fault    (ret_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      st_q.priv <= PRV_M;
      hdl_q   <= TGT_NONE;
      cause_r <= '0;
      swap_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (trap_req) begin
      st_q    <= ent_nxt;
      hdl_q   <= tgt;
      cause_r <= eff_cause;
      swap_q  <= ent_swap;
      fault_q <= 1'b0;
    end else if (ret_req) begin
      st_q    <= ret_nxt;
      swap_q  <= ret_swap;
      fault_q <= ret_bad;
    end else begin
      swap_q  <= 1'b0;
      fault_q <= 1'b0;
    end
  end

  assign cur_priv    = st_q.priv;
  assign cur_virt    = st_q.virt;
  assign m_prev_priv = st_q.m_pp;
  assign m_prev_virt = st_q.m_pv;
  assign s_prev_priv = st_q.s_pp;
  assign s_prev_virt = st_q.s_pv;
  assign m_ie        = st_q.m_ie;
  assign m_pie       = st_q.m_pie;
  assign s_ie        = st_q.s_ie;
  assign s_pie       = st_q.s_pie;
  assign handler     = hdl_q;
  assign cause_q     = cause_r;
  assign swap_strobe = swap_q;
  assign ret_fault   = fault_q;

  AST_HOST_TRAP_NO_GUEST: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !st_q.virt) |-> (tgt != TGT_VS)); // R2

  AST_HOST_FAULT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_host_fault && !trap_is_irq && !trap_is_ecall) |-> (tgt != TGT_VS)); // R4

  AST_GUEST_ENTRY_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (trap_req && tgt == TGT_VS) |=> (st_q.virt && $stable(st_q.s_pv) && !swap_q)); // R7

  AST_SWAP_ON_V_CHANGE: assert property (@(posedge clk) disable iff (rst)
    swap_q == (st_q.virt != $past(st_q.virt))); // R8

  AST_MACHINE_NOT_VIRT: assert property (@(posedge clk) disable iff (rst)
    (st_q.priv == PRV_M) |-> !st_q.virt); // R9

  AST_BAD_HRET_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    ret_fault |-> $stable(st_q)); // R11

  AST_TRAP_BEATS_RET: assert property (@(posedge clk) disable iff (rst)
    (trap_req && ret_req) |=> (!fault_q && hdl_q == $past(tgt))); // R13

endmodule

// File: tb/vtrap_ctrl_tb_top.sv
module vtrap_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int NC = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trap_req = 0, trap_is_irq = 0, trap_is_ecall = 0, trap_host_fault = 0;
  logic [CW-1:0] trap_code = '0;
  logic [NC-1:0] mdel_exc = '0, mdel_irq = '0, hdel_exc = '0, hdel_irq = '0;
  logic          ret_req = 0, sret_trap_ctl = 0;
  logic [1:0]    ret_kind = 0;

  logic [1:0]    cur_priv, m_prev_priv, handler;
  logic          cur_virt, m_prev_virt, s_prev_priv, s_prev_virt;
  logic          m_ie, m_pie, s_ie, s_pie, swap_strobe, ret_fault;
  logic [CW-1:0] cause_q;

  int n_vec = 0;
  int n_bad = 0;

  logic [1:0]    e_priv, e_mpp, e_hdl;
  logic          e_virt, e_mpv, e_spp, e_spv, e_mie, e_mpie, e_sie, e_spie, e_swap, e_fault;
  logic [CW-1:0] e_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtrap_ctrl #(.CAUSE_W(CW)) dut_i (
    .clk, .rst, .trap_req, .trap_is_irq, .trap_is_ecall, .trap_code, .trap_host_fault,
    .mdel_exc, .mdel_irq, .hdel_exc, .hdel_irq, .ret_req, .ret_kind, .sret_trap_ctl,
    .cur_priv, .cur_virt, .m_prev_priv, .m_prev_virt, .s_prev_priv, .s_prev_virt,
    .m_ie, .m_pie, .s_ie, .s_pie, .handler, .cause_q, .swap_strobe, .ret_fault
  );

  function automatic logic [21:0] act_vec();
    return {cur_priv, cur_virt, m_prev_priv, m_prev_virt, s_prev_priv, s_prev_virt,
            m_ie, m_pie, s_ie, s_pie, handler, cause_q, swap_strobe, ret_fault};
  endfunction

  function automatic logic [21:0] exp_vec();
    return {e_priv, e_virt, e_mpp, e_mpv, e_spp, e_spv,
            e_mie, e_mpie, e_sie, e_spie, e_hdl, e_cause, e_swap, e_fault};
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (act_vec() !== exp_vec()) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act_vec(), exp_vec());
    end
  endtask

  task automatic model_reset();
    e_priv = 2'd3; e_virt = 0; e_mpp = 0; e_mpv = 0; e_spp = 0; e_spv = 0;
    e_mie = 0; e_mpie = 0; e_sie = 0; e_spie = 0; e_hdl = 0; e_cause = '0;
    e_swap = 0; e_fault = 0;
  endtask

  // Independent reference of R2..R14; returns the target-based tag for traps.
  task automatic model_step(output string tag);
    logic old_v, irq, md, hd;
    logic [CW-1:0] c;
    tag = "R8";
    if (trap_req) begin
      if (trap_is_ecall) begin
        if (e_priv == 2'd0)      c = CW'(8);
        else if (e_priv == 2'd3) c = CW'(11);
        else                     c = e_virt ? CW'(10) : CW'(9);
      end else c = trap_code;
      irq = trap_is_irq && !trap_is_ecall;
      md = irq ? mdel_irq[c] : mdel_exc[c];
      hd = irq ? hdel_irq[c] : hdel_exc[c];
      e_cause = c; e_fault = 0;
      if (e_priv == 2'd3 || !md) begin
        e_mpv = e_virt; e_mpp = e_priv; e_mpie = e_mie; e_mie = 0;
        e_swap = e_virt; e_priv = 2'd3; e_virt = 0; e_hdl = 2'd3; tag = "R5";
      end else if (e_virt && hd && !(trap_host_fault && !irq)) begin
        e_spp = e_priv[0]; e_spie = e_sie; e_sie = 0; e_priv = 2'd1;
        e_swap = 0; e_hdl = 2'd2; tag = "R7";
      end else begin
        e_spv = e_virt; e_spp = e_priv[0]; e_spie = e_sie; e_sie = 0;
        e_swap = e_virt; e_virt = 0; e_priv = 2'd1; e_hdl = 2'd1; tag = "R6";
      end
    end else if (ret_req) begin
      old_v = e_virt; e_fault = 0;
      if (ret_kind == 2'd0) begin
        e_priv = e_mpp; e_virt = (e_mpp == 2'd3) ? 1'b0 : e_mpv;
        e_mpp = 0; e_mie = e_mpie; e_mpie = 1; tag = "R9";
      end else if (ret_kind == 2'd3) begin
        tag = "R10";
      end else if (ret_kind == 2'd2 &&
                   !(e_priv == 2'd3 || (e_priv == 2'd1 && !e_virt && !sret_trap_ctl))) begin
        e_fault = 1; tag = "R11";
      end else begin
        if (ret_kind == 2'd2) e_spv = 1;
        if (!e_virt) e_virt = e_spv;
        e_priv = e_spp ? 2'd1 : 2'd0;
        e_spp = 0; e_sie = e_spie; e_spie = 1;
        tag = (ret_kind == 2'd2) ? "R11" : "R10";
      end
      e_swap = (e_virt != old_v);
    end else begin
      e_swap = 0; e_fault = 0;
    end
  endtask

  task automatic op(input logic t, input logic irq, input logic ec, input logic [CW-1:0] code,
                    input logic hf, input logic r, input logic [1:0] k, input logic tc,
                    input string tag);
    string mtag;
    @(negedge clk);
    trap_req = t; trap_is_irq = irq; trap_is_ecall = ec; trap_code = code;
    trap_host_fault = hf; ret_req = r; ret_kind = k; sret_trap_ctl = tc;
    model_step(mtag);
    @(posedge clk);
    #1;
    check(tag == "" ? mtag : tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R1");

    mdel_exc = '1; mdel_irq = '0; hdel_exc = '1; hdel_irq = '0;
    op(0, 0, 0, 0,  0, 1, 2'd2, 0, "R11"); // hypervisor return from machine, enters guest user
    op(1, 0, 0, 2,  0, 0, 2'd0, 0, "R7");  // delegated twice, guest handles
    op(1, 0, 0, 13, 1, 0, 2'd0, 0, "R4");  // host-level fault stays with host
    mdel_exc = ~(NC'(1) << 9);
    op(1, 0, 1, 0,  0, 0, 2'd0, 0, "R12"); // ecall from host supervisor, cause 9, to machine
    op(0, 0, 0, 0,  0, 1, 2'd0, 0, "R9");  // machine return to host supervisor
    op(0, 0, 0, 0,  0, 1, 2'd1, 0, "R14"); // supervisor return enters guest, swap
    op(1, 1, 0, 5,  0, 1, 2'd1, 0, "R13"); // trap and return together
    op(0, 0, 0, 0,  0, 1, 2'd0, 0, "R9");  // back to guest supervisor
    op(0, 0, 0, 0,  0, 1, 2'd2, 0, "R11"); // hypervisor return illegal in guest
    op(0, 0, 0, 0,  0, 0, 2'd0, 0, "R8");  // fault pulse ends
    op(0, 0, 0, 0,  0, 1, 2'd1, 0, "R10"); // supervisor return while virtual
    hdel_exc = '0;
    op(1, 0, 0, 3,  0, 0, 2'd0, 0, "R3");  // machine bit only, host handles
    hdel_exc = '1;
    op(1, 0, 0, 3,  0, 0, 2'd0, 0, "R2");  // not virtual, hypervisor mask ignored
    mdel_exc = '1;
    op(1, 0, 1, 0,  0, 0, 2'd0, 0, "R12"); // ecall from host, delegated, cause 9
    op(0, 0, 0, 0,  0, 1, 2'd1, 1, "R10"); // sret from host
    op(0, 0, 0, 0,  0, 0, 2'd0, 0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic t, r;
      int sel;
      if (i % 50 == 0) begin
        mdel_exc = {$urandom, $urandom} | NC'($urandom);
        mdel_irq = NC'($urandom) | NC'($urandom);
        hdel_exc = NC'($urandom);
        hdel_irq = NC'($urandom);
      end
      sel = $urandom_range(0, 9);
      t = (sel < 4) || (sel == 9);
      r = (sel >= 4);
      op(t, 1'($urandom), ($urandom_range(0, 6) == 0), CW'($urandom),
         ($urandom_range(0, 4) == 0), r, 2'($urandom), 1'($urandom), "");
    end

    @(negedge clk);
    trap_req = 0; ret_req = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule